// File: doc/BRIEF.md
# Card Reset and Ready Sequencer

This block sits on the card side of a removable storage interface. It decides when the card logic is held in reset and when the card reports itself ready to the host. Three things can put the card into reset. The first is the power-on reset. The second is the host's hardware reset pin, which is active high in the memory and I/O interface modes and active low in the IDE-style mode. The third is a soft-reset bit in a host-writable option register.

A reset level that the host leaves on the pin from power-up must not keep the card busy forever. After the power-on reset, the pin is therefore acted on only when it moves from deasserted to asserted.

Once a reset cause has gone away, the sequencer releases the internal reset and runs an initialisation window. The window is a parameter in clock cycles, and a done input from the initialisation logic can end it early. After the window, READY follows the card's busy indication. The interface mode is sampled during the power-on reset and sets the pin polarity until the next power cycle.

Top module: `card_rst_seq`

## Requirements
- R1: While `rst_n` is low (power-on reset), `card_rst_n_o`, `ready_o` and `cfg_q_o` are all 0.
- R2: After `rst_n` is released, `card_rst_n_o` is 1 from the first clock edge, and `ready_o` stays low for exactly INIT_CYCLES cycles (default 40) before it rises.
- R3: `ide_mode_i` is sampled only while `rst_n` is low. A value of 1 makes the reset pin active low, and 0 makes it active high. Changes after power-up have no effect on the polarity.
- R4: A pin level that is present from power-up is ignored, so the power-up initialisation completes normally. After power-up, a transition of the pin from deasserted to asserted drives `card_rst_n_o` low at the third clock edge after the pin changes. It stays low while the pin stays asserted. After release, a full INIT_CYCLES window runs.
- R5: A recognised hardware reset transition clears every bit of the option register to 0.
- R6: Bit SRST_BIT (default bit 7) of the option register is the soft reset. From the second edge after a write sets it, `card_rst_n_o` and `ready_o` are low for as long as the bit stays 1. Clearing the bit starts a full INIT_CYCLES window.
- R7: A write with `cfg_we_i` high stores `cfg_wdata_i`, which is visible on `cfg_q_o` after the clock edge. Writes with the soft-reset bit at 0 do not disturb `ready_o`.
- R8: `init_done_i` high during the initialisation window ends the window at the next clock edge.
- R9: Once the window has ended, `ready_o` equals the inverse of `busy_i` in the same cycle.
- R10: Setting the soft-reset bit in the middle of an initialisation window aborts that window. The window that follows the clearing of the bit lasts the full INIT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| ide_mode_i | input | 1 | Interface mode select: 1 selects the IDE-style mode (active-low reset pin) |
| hw_rst_pin_i | input | 1 | Raw host reset pin, asynchronous |
| cfg_we_i | input | 1 | Option register write strobe |
| cfg_wdata_i | input | CFG_W | Option register write data |
| init_done_i | input | 1 | Initialisation logic has finished |
| busy_i | input | 1 | Card is busy with a transfer |
| cfg_q_o | output | CFG_W | Option register contents |
| card_rst_n_o | output | 1 | Internal reset for the card logic, active low |
| ready_o | output | 1 | READY to host; low while busy or initialising |

## Verification
The bench holds the reset pin asserted from power-up in both modes. A level-sensitive design would keep the card busy indefinitely, and one with badly initialised synchronizer flops would see a false edge and reset a second time.

The bench then toggles the mode input after power-up to catch a design that re-reads the polarity. It sets the soft-reset bit in the middle of an initialisation window to catch a counter that resumes instead of restarting. It also measures each window to the cycle, so an off-by-one in the count, or a done input that is ignored, shows up as a wrong length.

A hardware reset is issued after a non-zero option write, which exposes a design that leaves the register intact.

// File: rtl/crs_pkg.sv
// Shared types for the card reset and ready sequencer.
package crs_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,   // internal reset asserted
        SEQ_INIT = 2'd1,   // initialisation window running
        SEQ_RUN  = 2'd2    // ready follows busy
    } seq_state_e;
endpackage

// File: rtl/crs_pin_front.sv
// Reset pin front end: latches the interface mode during power-on reset,
// synchronises the raw pin and converts it to an "asserted" level, and
// reports deasserted-to-asserted transitions.
// Assumes SYNC_STAGES >= 2. The synchronizer resets to the asserted pin
// value, so a level held since power-up never looks like a transition.
module crs_pin_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic                   mode_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Sample the mode only while power-on reset is active.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_i;
    end

    // Synchronise the pin; preset to the raw asserted value for the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{~mode_i}};
        else        sync_q <= {sync_q[MSB-1:0], pin_i};
    end

    assign level_o = mode_q ? ~sync_q[MSB] : sync_q[MSB];

    // Remember the previous level; starts as asserted so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/crs_cfg_reg.sv
// Option register written by the host. A hardware reset event clears it,
// and it has priority over a write in the same cycle.
module crs_cfg_reg #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] q_o
);
    // Hold, clear or load the register contents.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) q_o <= '0;
        else if (we_i)       q_o <= wdata_i;
    end
endmodule

// File: rtl/crs_init_timer.sv
// Initialisation window timer: counts while run_i is high and flags the
// last cycle of a CYCLES-long window. Drops back to zero when run_i falls.
// Assumes CYCLES >= 1.
module crs_init_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles of the window; restart whenever the window is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (!expire_o)   cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/card_rst_seq.sv
// Card reset and ready sequencer. Combines the power-on reset, an
// edge-qualified host reset pin and a soft-reset bit into one internal
// reset. After a cause clears, it runs an initialisation window, then lets
// READY follow the busy input.
// Assumes busy_i and init_done_i are synchronous to clk.
module card_rst_seq #(
    parameter int CFG_W       = 8,
    parameter int SRST_BIT    = 7,
    parameter int INIT_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ide_mode_i,
    input  logic             hw_rst_pin_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             init_done_i,
    input  logic             busy_i,
    output logic [CFG_W-1:0] cfg_q_o,
    output logic             card_rst_n_o,
    output logic             ready_o
);
    import crs_pkg::*;

    logic       pin_level;
    logic       pin_rise;
    logic       hw_hold_q;
    logic       soft_rst;
    logic       win_expire;
    seq_state_e state_q, state_d;

    crs_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (ide_mode_i),
        .pin_i   (hw_rst_pin_i),
        .level_o (pin_level),
        .rise_o  (pin_rise)
    );

    crs_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pin_rise),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .q_o     (cfg_q_o)
    );

    crs_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == SEQ_INIT),
        .expire_o (win_expire)
    );

    assign soft_rst = cfg_q_o[SRST_BIT];

    // Track a hardware reset that began with a transition, until release.
    always_ff @(posedge clk) begin
        if (!rst_n)          hw_hold_q <= 1'b0;
        else if (pin_rise)   hw_hold_q <= 1'b1;
        else if (!pin_level) hw_hold_q <= 1'b0;
    end

    // Next-state selection: any reset cause forces HOLD.
    always_comb begin
        state_d = state_q;
        if (pin_rise || soft_rst) begin
            state_d = SEQ_HOLD;
        end else begin
            case (state_q)
                SEQ_HOLD: if (!(hw_hold_q && pin_level)) state_d = SEQ_INIT;
                SEQ_INIT: if (win_expire || init_done_i) state_d = SEQ_RUN;
                SEQ_RUN:  state_d = SEQ_RUN;
                default:  state_d = SEQ_HOLD;
            endcase
        end
    end

    // State register; power-on reset starts in HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_HOLD;
        else        state_q <= state_d;
    end

    assign card_rst_n_o = (state_q != SEQ_HOLD);
    assign ready_o      = (state_q == SEQ_RUN) && !busy_i;
endmodule

// File: rtl/crs_checker.sv
// Property checker for card_rst_seq, attached with bind.
module crs_checker #(
    parameter int CFG_W       = 8,
    parameter int SRST_BIT    = 7,
    parameter int INIT_CYCLES = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_i,
    input logic [CFG_W-1:0] cfg_q_o,
    input logic             card_rst_n_o,
    input logic             ready_o
);
    int unsigned win_cnt;

    // Length of the current stretch with reset released, not ready, not busy.
    always_ff @(posedge clk) begin
        if (!rst_n || ready_o || !card_rst_n_o) win_cnt <= 0;
        else if (!busy_i)                       win_cnt <= win_cnt + 1;
    end

    // R1
    por_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!card_rst_n_o && !ready_o));

    // R2
    release_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n_o) |-> !ready_o);

    // R6
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q_o[SRST_BIT] |=> (!card_rst_n_o && !ready_o));

    // R9
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !busy_i);

    // R2
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= INIT_CYCLES);
endmodule

bind card_rst_seq crs_checker #(
    .CFG_W(CFG_W), .SRST_BIT(SRST_BIT), .INIT_CYCLES(INIT_CYCLES)
) u_crs_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .cfg_q_o(cfg_q_o),
    .card_rst_n_o(card_rst_n_o), .ready_o(ready_o)
);

// File: tb/card_rst_seq_test.sv
module card_rst_seq_test;
    localparam int IC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ide_mode = 1'b0;
    logic       pin = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       done = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] cfg_q;
    logic       crst_n;
    logic       ready;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    card_rst_seq #(.CFG_W(8), .SRST_BIT(7), .INIT_CYCLES(IC), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ide_mode_i(ide_mode), .hw_rst_pin_i(pin),
        .cfg_we_i(we), .cfg_wdata_i(wdata), .init_done_i(done), .busy_i(busy),
        .cfg_q_o(cfg_q), .card_rst_n_o(crst_n), .ready_o(ready)
    );

    always #4 clk = ~clk;

    // {wdata[7:0], busy, expected ready}; soft-reset bit kept 0
    localparam logic [9:0] VEC [6] = '{
        {8'h00, 1'b0, 1'b1}, {8'h5A, 1'b1, 1'b0}, {8'h7F, 1'b0, 1'b1},
        {8'h01, 1'b1, 1'b0}, {8'h3C, 1'b0, 1'b1}, {8'h00, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Waits for reset release, then counts not-ready samples; -1 if stuck.
    task automatic measure(output int n, input int done_after);
        int guard = 0;
        n = 0;
        while (!crst_n && guard < 1000) begin @(negedge clk); guard++; end
        while (!ready && guard < 1000) begin
            n++;
            if (n == done_after) done = 1'b1;
            @(negedge clk);
            guard++;
        end
        done = 1'b0;
        if (guard >= 1000) n = -1;
    endtask

    initial begin
        int m;
        // Memory mode power-up with the pin held asserted (high).
        idle(3);
        check("R1 rst_n", crst_n, 0);
        check("R1 ready", ready, 0);
        check("R1 cfg", cfg_q, 0);
        rst_n = 1'b1;
        measure(m, 0);
        check("R2/R4 power-up window, pin held", m, IC);

        // Vector table: option writes and busy patterns.
        for (int i = 0; i < 6; i++) begin
            busy = VEC[i][1];
            cfg_write(VEC[i][9:2]);
            check("R7 cfg readback", cfg_q, VEC[i][9:2]);
            check("R9 ready vs busy", ready, VEC[i][0]);
        end
        busy = 1'b0;

        // R3: mode change after power-up is ignored.
        ide_mode = 1'b1;
        idle(6);
        check("R3 mode flip ignored", crst_n, 1);
        pin = 1'b0;
        idle(6);
        check("R3 pin low still deasserted", ready, 1);
        ide_mode = 1'b0;

        // R4/R5: edge-triggered hardware reset.
        cfg_write(8'h2A);
        pin = 1'b1;
        idle(2);
        check("R4 before third edge", crst_n, 1);
        idle(1);
        check("R4 reset at third edge", crst_n, 0);
        check("R5 cfg cleared", cfg_q, 0);
        idle(10);
        check("R4 held while asserted", crst_n, 0);
        pin = 1'b0;
        measure(m, 0);
        check("R4 window after release", m, IC);

        // R6: soft reset.
        cfg_write(8'h80);
        check("R6 not before second edge", crst_n, 1);
        idle(1);
        check("R6 reset asserted", crst_n, 0);
        idle(20);
        check("R6 held while bit set", ready, 0);
        check("R6 bit retained", cfg_q, 8'h80);
        cfg_write(8'h00);
        measure(m, 0);
        check("R6 window after clear", m, IC);

        // R10: soft reset in the middle of a window.
        cfg_write(8'h80);
        idle(3);
        cfg_write(8'h00);
        idle(10);
        check("R10 mid-window", crst_n, 1);
        cfg_write(8'h80);
        idle(2);
        check("R10 window aborted", crst_n, 0);
        cfg_write(8'h00);
        measure(m, 0);
        check("R10 full window again", m, IC);

        // R8: done input ends the window early.
        cfg_write(8'h80);
        idle(2);
        cfg_write(8'h00);
        measure(m, 5);
        check("R8 early done", m, 5);

        // R3: IDE mode power-up with the pin held low (asserted).
        rst_n = 1'b0; ide_mode = 1'b1; pin = 1'b0;
        idle(4);
        check("R1 second power-up", crst_n, 0);
        rst_n = 1'b1;
        measure(m, 0);
        check("R3 IDE power-up window", m, IC);
        pin = 1'b1;
        idle(6);
        check("R3 IDE pin high is deasserted", ready, 1);
        pin = 1'b0;
        idle(3);
        check("R3 IDE falling pin resets", crst_n, 0);
        pin = 1'b1;
        measure(m, 0);
        check("R3 IDE window after release", m, IC);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule